// File: doc/BRIEF.md
# Time-Triggered Bus Frame Serializer

This block builds one frame for a time-triggered field bus and sends it as a serial bit stream, one bit per strobed cycle. On a start request it captures a slot identifier, a protocol cycle number and a payload byte count. It then sends the header, a check code that protects the header, the cycle number, the payload bytes and a trailer check code that covers every bit before it. The fields go out in that order, and every field is sent most-significant bit first.

Payload bytes come from a host-side buffer through a ready/valid handshake. Each bit is marked by a strobe, and the stream pauses with the strobe low while the block waits for a payload byte. The block rejects a byte count that cannot be written as a whole number of 16-bit words, or that is larger than the largest payload. It raises an error pulse for that request and sends nothing. A one-cycle done pulse closes each frame, and the block accepts a new request only after that pulse.

Top module: `ttbus_frame_tx`

## Requirements
- R1: The first 18 bits of a frame are the 11-bit frame identifier and then the 7-bit length field. The length field holds the byte count divided by two. Both are sent MSB first.
- R2: The next 11 bits are the header check code, sent MSB first. It is computed MSB first over the 18 identifier and length bits, with polynomial 0x385 and start value 0x01A. For each bit, feedback is the code's top bit XOR the data bit. The code shifts left one place and is XORed with the polynomial when the feedback is 1.
- R3: A start request with an odd byte count, or a count above 254, raises `err` for exactly one cycle, the cycle after the request. No bit is strobed and `busy` stays low.
- R4: The 6-bit cycle number follows the header check code, MSB first.
- R5: Payload bytes follow in the order the handshake accepted them, each MSB first. A byte is accepted on a clock edge where `pl_valid` and `pl_ready` are both high. While the block waits for a byte, `bit_strobe` is low.
- R6: The last 24 bits are the trailer check code, sent MSB first. It is computed the same way as in R2, with polynomial 0x5D6DCB and start value 0xFEDCBA, over every earlier bit of the frame.
- R7: A frame with n payload bytes has exactly 59 + 8n strobed bits. `bit_out` is 0 in any cycle where `bit_strobe` is low.
- R8: `done` is high for exactly one cycle, the cycle right after the last trailer bit. `busy` goes low in the cycle after `done`.
- R9: A start request while `busy` is high is ignored. The identifier, cycle number and byte count are captured at the start request, and later changes to those inputs do not affect the frame.
- R10: After reset, `busy`, `bit_strobe`, `bit_out`, `pl_ready`, `done` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send one frame |
| frame_id | input | 11 | Slot identifier |
| cycle_num | input | 6 | Protocol cycle number |
| byte_count | input | 8 | Payload length in bytes |
| pl_data | input | 8 | Payload byte from the host buffer |
| pl_valid | input | 1 | Payload byte available |
| pl_ready | output | 1 | Block takes a payload byte |
| bit_out | output | 1 | Serial frame bit |
| bit_strobe | output | 1 | `bit_out` carries a frame bit this cycle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished |
| err | output | 1 | Start request rejected |

## Verification
The bench builds the block with its default parameters. These are the real field widths and the full 0 to 254 byte range, so the largest frame and every possible rejected count are reachable. It sweeps every even byte count from 0 to 30, sends frames at 252 and 254 bytes with identifiers at both ends of the range, and sends all 128 odd counts as requests that must be rejected. Some frames throttle `pl_valid` so the stream has to pause. Some frames send a start request while busy and change the captured inputs in the middle of the frame.

// File: rtl/ttbus_frame_tx.sv
module ttbus_frame_tx #(
  parameter int ID_W      = 11,
  parameter int LEN_W     = 7,
  parameter int CYC_W     = 6,
  parameter int HCRC_W    = 11,
  parameter int TCRC_W    = 24,
  parameter logic [HCRC_W-1:0] HCRC_POLY = 11'h385,
  parameter logic [HCRC_W-1:0] HCRC_INIT = 11'h01A,
  parameter logic [TCRC_W-1:0] TCRC_POLY = 24'h5D6DCB,
  parameter logic [TCRC_W-1:0] TCRC_INIT = 24'hFEDCBA,
  parameter int MAX_BYTES = 254
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ID_W-1:0]  frame_id,
  input  logic [CYC_W-1:0] cycle_num,
  input  logic [LEN_W:0]   byte_count,
  input  logic [7:0]       pl_data,
  input  logic             pl_valid,
  output logic             pl_ready,
  output logic             bit_out,
  output logic             bit_strobe,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam int BC_W  = LEN_W + 1;
  localparam int HDR_W = ID_W + LEN_W;
  localparam int SR_W  = TCRC_W;
  localparam int CNT_W = $clog2(SR_W);
  localparam int OVH   = HDR_W + HCRC_W + CYC_W + TCRC_W;
  localparam int SC_W  = $clog2(OVH + 8 * MAX_BYTES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_HCRC, S_CYC, S_FETCH, S_DATA, S_TCRC, S_DONE
  } state_t;

  state_t            state;
  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  cnt;
  logic [HCRC_W-1:0] hcrc;
  logic [TCRC_W-1:0] tcrc;
  logic [CYC_W-1:0]  cyc_q;
  logic [LEN_W-1:0]  len_q;
  logic [BC_W-1:0]   bytes_left;
  logic [SC_W-1:0]   sent_cnt;

  logic              bit_now, last_bit, bad_req;
  logic [HCRC_W-1:0] hcrc_nx;
  logic [TCRC_W-1:0] tcrc_nx;

  assign bit_now    = sr[SR_W-1];
  assign bit_strobe = state inside {S_HDR, S_HCRC, S_CYC, S_DATA, S_TCRC};
  assign last_bit   = bit_strobe && (cnt == '0);
  assign bit_out    = bit_strobe & bit_now;
  assign pl_ready   = (state == S_FETCH);
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign bad_req    = byte_count[0] || (byte_count > BC_W'(MAX_BYTES));

  assign hcrc_nx = {hcrc[HCRC_W-2:0], 1'b0} ^ ((hcrc[HCRC_W-1] ^ bit_now) ? HCRC_POLY : '0);
  assign tcrc_nx = {tcrc[TCRC_W-2:0], 1'b0} ^ ((tcrc[TCRC_W-1] ^ bit_now) ? TCRC_POLY : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      sr         <= '0;
      cnt        <= '0;
      hcrc       <= '0;
      tcrc       <= '0;
      cyc_q      <= '0;
      len_q      <= '0;
      bytes_left <= '0;
      sent_cnt   <= '0;
      err        <= 1'b0;
    end else begin
      err <= 1'b0;
      if (bit_strobe) begin
        sr       <= sr << 1;
        cnt      <= cnt - 1'b1;
        sent_cnt <= sent_cnt + 1'b1;
        if (state != S_TCRC) tcrc <= tcrc_nx;
        if (state == S_HDR)  hcrc <= hcrc_nx;
      end
      case (state)
        S_IDLE: if (start) begin
          if (bad_req) begin
            err <= 1'b1;
          end else begin
            sr         <= {frame_id, byte_count[BC_W-1:1], {(SR_W-HDR_W){1'b0}}};
            cnt        <= CNT_W'(HDR_W - 1);
            hcrc       <= HCRC_INIT;
            tcrc       <= TCRC_INIT;
            cyc_q      <= cycle_num;
            len_q      <= byte_count[BC_W-1:1];
            bytes_left <= byte_count;
            sent_cnt   <= '0;
            state      <= S_HDR;
          end
        end
        S_HDR: if (last_bit) begin
          sr    <= {hcrc_nx, {(SR_W-HCRC_W){1'b0}}};
          cnt   <= CNT_W'(HCRC_W - 1);
          state <= S_HCRC;
        end
        S_HCRC: if (last_bit) begin
          sr    <= {cyc_q, {(SR_W-CYC_W){1'b0}}};
          cnt   <= CNT_W'(CYC_W - 1);
          state <= S_CYC;
        end
        S_CYC, S_DATA: if (last_bit) begin
          if (bytes_left == '0) begin
            sr    <= tcrc_nx;
            cnt   <= CNT_W'(TCRC_W - 1);
            state <= S_TCRC;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: if (pl_valid) begin
          sr         <= {pl_data, {(SR_W-8){1'b0}}};
          cnt        <= CNT_W'(7);
          bytes_left <= bytes_left - 1'b1;
          state      <= S_DATA;
        end
        S_TCRC: if (last_bit) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_reject_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_req) |=> (err && !busy && !bit_strobe));

  assert_err_no_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  assert_wait_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> !bit_strobe);

  assert_bit_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sent_cnt == SC_W'(OVH) + (SC_W'(len_q) << 4)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: tb/ttbus_frame_tx_tb.sv
module ttbus_frame_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] frame_id = '0;
  logic [5:0]  cycle_num = '0;
  logic [7:0]  byte_count = '0;
  logic [7:0]  pl_data = '0;
  logic        pl_valid = 1'b0;
  logic        pl_ready, bit_out, bit_strobe, busy, done, err;

  int checks = 0;
  int errors = 0;
  bit exp_bits [0:2199];
  int exp_len;
  logic [7:0] pay [0:253];

  always #10 clk = ~clk;

  ttbus_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_id(frame_id),
    .cycle_num(cycle_num), .byte_count(byte_count), .pl_data(pl_data),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .bit_out(bit_out),
    .bit_strobe(bit_strobe), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] h_step(logic [10:0] c, bit b);
    return {c[9:0], 1'b0} ^ ((c[10] ^ b) ? 11'h385 : 11'h000);
  endfunction

  function automatic logic [23:0] t_step(logic [23:0] c, bit b);
    return {c[22:0], 1'b0} ^ ((c[23] ^ b) ? 24'h5D6DCB : 24'h000000);
  endfunction

  task automatic build_exp(input logic [10:0] id, input logic [5:0] cy, input int nb);
    logic [10:0] h;
    logic [23:0] t;
    logic [6:0]  len;
    logic [10:0] hs;
    h = 11'h01A; t = 24'hFEDCBA; exp_len = 0; len = 7'(nb / 2);
    for (int i = 10; i >= 0; i--) begin
      exp_bits[exp_len] = id[i]; exp_len++; h = h_step(h, id[i]); t = t_step(t, id[i]);
    end
    for (int i = 6; i >= 0; i--) begin
      exp_bits[exp_len] = len[i]; exp_len++; h = h_step(h, len[i]); t = t_step(t, len[i]);
    end
    hs = h;
    for (int i = 10; i >= 0; i--) begin
      exp_bits[exp_len] = hs[i]; exp_len++; t = t_step(t, hs[i]);
    end
    for (int i = 5; i >= 0; i--) begin
      exp_bits[exp_len] = cy[i]; exp_len++; t = t_step(t, cy[i]);
    end
    for (int k = 0; k < nb; k++)
      for (int i = 7; i >= 0; i--) begin
        exp_bits[exp_len] = pay[k][i]; exp_len++; t = t_step(t, pay[k][i]);
      end
    for (int i = 23; i >= 0; i--) begin
      exp_bits[exp_len] = t[i]; exp_len++;
    end
  endtask

  task automatic run_frame(input logic [10:0] id, input logic [5:0] cy, input int nb,
                           input int seed, input bit stall, input bit poke);
    int c, got, idx, last_c, done_c, done_n, err_n, quiet_bad;
    int m_r1, m_r2, m_r4, m_r5, m_r6;
    for (int k = 0; k < nb; k++) pay[k] = 8'((k * 37 + seed * 11 + 3) & 255);
    build_exp(id, cy, nb);
    @(negedge clk);
    start = 1'b1; frame_id = id; cycle_num = cy; byte_count = 8'(nb);
    @(negedge clk);
    start = 1'b0; frame_id = ~id; cycle_num = ~cy; byte_count = 8'd7;
    c = 0; got = 0; idx = 0; last_c = -10; done_c = -20; done_n = 0; err_n = 0; quiet_bad = 0;
    m_r1 = 0; m_r2 = 0; m_r4 = 0; m_r5 = 0; m_r6 = 0;
    while (busy && c < 8000) begin
      if (bit_strobe) begin
        if (got < exp_len && bit_out != exp_bits[got]) begin
          if (got < 18) m_r1++;
          else if (got < 29) m_r2++;
          else if (got < 35) m_r4++;
          else if (got < 35 + 8 * nb) m_r5++;
          else m_r6++;
        end
        got++; last_c = c;
      end else if (bit_out) quiet_bad++;
      if (done) begin done_n++; done_c = c; end
      if (err) err_n++;
      if (poke && c == 20) begin start = 1'b1; byte_count = 8'd3; end
      else start = 1'b0;
      pl_valid = stall ? ((c % 3) == 1) : 1'b1;
      pl_data = (idx < nb) ? pay[idx] : 8'h00;
      if (pl_ready && pl_valid) idx++;
      c++;
      @(negedge clk);
    end
    pl_valid = 1'b0; start = 1'b0;
    if (err) err_n++;
    chk(c < 8000, "R8 frame ends", c, 8000);
    chk(m_r1 == 0, "R1 id/len bits", m_r1, 0);
    chk(m_r2 == 0, "R2 header crc bits", m_r2, 0);
    chk(m_r4 == 0, "R4 cycle bits", m_r4, 0);
    chk(m_r5 == 0, "R5 payload bits", m_r5, 0);
    chk(m_r6 == 0, "R6 trailer crc bits", m_r6, 0);
    chk(got == exp_len, "R7 bit count", got, exp_len);
    chk(quiet_bad == 0, "R7 idle line low", quiet_bad, 0);
    chk(idx == nb, "R5 bytes taken", idx, nb);
    chk(done_n == 1, "R8 done count", done_n, 1);
    chk(done_c == last_c + 1, "R8 done timing", done_c, last_c + 1);
    chk(err_n == 0, "R9 start ignored while busy", err_n, 0);
    chk(!busy && !done, "R8 idle after done", busy, 0);
  endtask

  task automatic reject(input int v);
    @(negedge clk);
    start = 1'b1; byte_count = 8'(v);
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy && !bit_strobe, "R3 rejected request", {err, busy, bit_strobe}, 4);
    @(negedge clk);
    chk(!err && !busy && !bit_strobe, "R3 error single pulse", {err, busy, bit_strobe}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, bit_strobe, bit_out, pl_ready, done, err} == 6'b0, "R10 reset state",
        {busy, bit_strobe, bit_out, pl_ready, done, err}, 0);
    for (int n = 0; n <= 30; n += 2)
      run_frame(11'((n * 61 + 5) & 2047), 6'(n), n, n, (n % 4) == 2, n == 10);
    run_frame(11'd2047, 6'd63, 254, 7, 1'b1, 1'b1);
    run_frame(11'd0, 6'd0, 252, 9, 1'b0, 1'b0);
    run_frame(11'd1024, 6'd42, 254, 13, 1'b0, 1'b1);
    for (int v = 1; v < 256; v += 2) reject(v);
    run_frame(11'h2AA, 6'h15, 2, 5, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule